// File: doc/BRIEF.md
# Byte-Serial Load/Store Sequencer

This block takes a single memory request and turns it into a series of 8-bit transfers on a simple chip-select bus. The request can be a byte, halfword or word load or store, a load or store of several registers, or a test-and-set on a halfword. The bus has an active-low select, a read/not-write line, a 24-bit address, and split data-in, data-out and output-enable lines that together act as the bidirectional data bus. Wider values travel most-significant byte first, and the byte addresses rise by one for each transfer.

A request is made up of an operation code, a short-form flag, a base value with a flag that forces the base to zero, a 16-bit displacement, store data and a register index. The block does not hold a register file. Each loaded word comes back on `rdata` with a one-hot register write strobe. For a store of several registers, the block shows the register index it wants on `reg_sel`, and the surrounding logic must drive that register's contents on `req_wdata`.

Top module: `bytewise_lsu`

## Requirements
- R1: The effective address is the sign-extended 16-bit displacement added to the low 24 bits of the base, or to zero when the zero-base flag is set. The sum wraps modulo 2^24, and no alignment check is made.
- R2: When the short-form flag is set on a single byte, halfword or word access, the displacement is `req_disp[3:0]` zero-extended and multiplied by 1, 2 or 4 respectively. The flag has no effect on multiple-register and test-and-set operations.
- R3: A load puts the first fetched byte in the most significant position of the accessed width, and the result is zero-extended to 32 bits. When the word completes, `rdata` carries the value and `reg_we` pulses for one clock at the bit of the destination register.
- R4: A word store sends `req_wdata` bits 31:24, 23:16, 15:8 and 7:0 in that order. A halfword store sends bits 15:8 and then 7:0. A byte store sends bits 7:0 only. Single stores use the data presented at acceptance.
- R5: A multiple-register operation moves one word for each register, from the start index up to 15, at ascending consecutive addresses. Loads pulse `reg_we` once for each register in that order. Stores take each word from `req_wdata` while `reg_sel` shows that register.
- R6: Test-and-set reads two bytes into the destination, returns them with a write strobe, and then writes 0xFF to the address of the first byte. That makes three bus transfers.
- R7: Each byte transfer lasts `CYC_CLKS` clocks. The select is low for the first (9*`CYC_CLKS`)/10 clocks and high for at least one clock after that. Read data is captured on the last low clock, and the address holds steady while the select is low.
- R8: Outside a transfer the select and read/not-write lines are high, the address is zero and the output enable is low. During a store transfer the output enable is high and read/not-write is low.
- R9: `busy` rises on acceptance and stays high for exactly (bytes moved) x `CYC_CLKS` clocks. `done` then pulses for one clock. A request made while `busy` is high is ignored.
- R10: After reset the block is idle: `busy`, `done` and `reg_we` are low and the bus is in its idle state.
- R11: Operation codes are 0 byte load, 1 halfword load, 2 word load, 3 multiple load, 4 byte store, 5 halfword store, 6 word store, 7 multiple store and 8 test-and-set. Any other code is ignored and starts no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 4 | Operation code (R11) |
| req_short | input | 1 | Short-form displacement select |
| req_base_zero | input | 1 | Use zero instead of the base value |
| req_base | input | 32 | Base register value |
| req_disp | input | 16 | Displacement |
| req_wdata | input | 32 | Store data (live per register for multiple store) |
| req_reg | input | 4 | Destination or starting register index |
| reg_sel | output | 4 | Register currently being transferred |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Assembled load result |
| reg_we | output | 16 | One-hot register write strobe |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_addr | output | 24 | Byte address |
| bus_dout | output | 8 | Write data |
| bus_doe | output | 1 | Write data drive enable |
| bus_din | input | 8 | Read data |

## Verification
On every cycle, the assertions check that the select never stays low longer than its share of a transfer, that the address holds while the select is low, that the bus stays idle whenever the block is not busy, that at most one register strobe is active, and that `done` is a lone pulse that comes with `busy` low. The bench scenarios are needed for the rest: the address arithmetic including the short form and the 24-bit wrap, big-endian assembly and byte order, the register sweep of the multiple-register operations, the 0xFF write-back of test-and-set, the exact busy length, and requests that must be ignored.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

    localparam int ADDR_W = 24;

    typedef enum logic [3:0] {
        OP_LDB = 4'd0,
        OP_LDH = 4'd1,
        OP_LDW = 4'd2,
        OP_LDM = 4'd3,
        OP_STB = 4'd4,
        OP_STH = 4'd5,
        OP_STW = 4'd6,
        OP_STM = 4'd7,
        OP_TAS = 4'd8
    } op_e;

    typedef struct packed {
        logic       valid;
        logic       load;
        logic       multi;
        logic       tas;
        logic [2:0] nbytes;
    } opinfo_t;

    function automatic opinfo_t op_decode(input logic [3:0] code);
        opinfo_t r;
        r        = '0;
        r.valid  = (code <= 4'd8);
        r.load   = (code <= 4'd3) || (code == 4'd8);
        r.multi  = (code == 4'd3) || (code == 4'd7);
        r.tas    = (code == 4'd8);
        case (code[1:0])
            2'd0:    r.nbytes = 3'd1;
            2'd1:    r.nbytes = 3'd2;
            default: r.nbytes = 3'd4;
        endcase
        if (r.tas) r.nbytes = 3'd2;
        return r;
    endfunction

    // byte k (0 = first sent) of an n-byte big-endian value held in w
    function automatic logic [7:0] pick_byte(input logic [31:0] w,
                                             input logic [2:0]  n,
                                             input logic [1:0]  k);
        logic [2:0] t;
        t = n - 3'd1 - {1'b0, k};
        return w[{t[1:0], 3'b000} +: 8];
    endfunction

endpackage

// File: rtl/lsq_ea.sv
module lsq_ea
    import lsq_pkg::*;
(
    input  logic [3:0]        op,
    input  logic              short_form,
    input  logic              base_zero,
    input  logic [31:0]       base_val,
    input  logic [15:0]       disp,
    output logic [ADDR_W-1:0] ea
);
    opinfo_t           inf;
    logic [ADDR_W-1:0] base_part;
    logic [ADDR_W-1:0] off;
    logic [1:0]        scale;

    always_comb begin
        inf       = op_decode(op);
        base_part = base_zero ? '0 : base_val[ADDR_W-1:0];
        scale     = (inf.nbytes == 3'd4) ? 2'd2 :
                    (inf.nbytes == 3'd2) ? 2'd1 : 2'd0;
        if (short_form && !inf.multi && !inf.tas)
            off = {{(ADDR_W-4){1'b0}}, disp[3:0]} << scale;
        else
            off = {{(ADDR_W-16){disp[15]}}, disp};
        ea = base_part + off;
    end
endmodule

// File: rtl/lsq_byte_timer.sv
module lsq_byte_timer #(
    parameter int CYC_CLKS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic cs_n,
    output logic sample_stb,
    output logic end_stb
);
    localparam int LOW_RAW  = (CYC_CLKS * 9) / 10;
    localparam int LOW_CLKS = (LOW_RAW < 1) ? 1 :
                              ((LOW_RAW >= CYC_CLKS) ? CYC_CLKS - 1 : LOW_RAW);
    localparam int CW       = $clog2(CYC_CLKS);

    logic [CW-1:0] cnt;

    assign cs_n       = !(active && (cnt < CW'(LOW_CLKS)));
    assign sample_stb = active && (cnt == CW'(LOW_CLKS - 1));
    assign end_stb    = active && (cnt == CW'(CYC_CLKS - 1));

    always_ff @(posedge clk) begin
        if (rst || !active || end_stb) cnt <= '0;
        else                           cnt <= cnt + 1'b1;
    end

    logic [CW:0] low_run;
    always_ff @(posedge clk) begin
        if (rst || cs_n) low_run <= '0;
        else             low_run <= low_run + 1'b1;
    end

    // R7
    low_len_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> (int'(low_run) < LOW_CLKS));
endmodule

// File: rtl/bytewise_lsu.sv
module bytewise_lsu
    import lsq_pkg::*;
#(
    parameter int CYC_CLKS = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [3:0]        req_op,
    input  logic              req_short,
    input  logic              req_base_zero,
    input  logic [31:0]       req_base,
    input  logic [15:0]       req_disp,
    input  logic [31:0]       req_wdata,
    input  logic [3:0]        req_reg,
    output logic [3:0]        reg_sel,
    output logic              busy,
    output logic              done,
    output logic [31:0]       rdata,
    output logic [15:0]       reg_we,
    output logic              bus_cs_n,
    output logic              bus_rw,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_dout,
    output logic              bus_doe,
    input  logic [7:0]        bus_din
);
    opinfo_t           inf;
    logic [ADDR_W-1:0] ea;
    logic              accept;

    logic              active, is_load, is_multi, is_tas, tas_wr;
    logic [2:0]        nbytes;
    logic [1:0]        bidx;
    logic [3:0]        cur_reg;
    logic [ADDR_W-1:0] addr_cur, addr_first;
    logic [31:0]       sdata, acc;
    logic              sample_stb, end_stb, wr_phase, last_byte;

    assign inf    = op_decode(req_op);
    assign accept = req_valid && !active && inf.valid;

    lsq_ea ea_i (
        .op(req_op), .short_form(req_short), .base_zero(req_base_zero),
        .base_val(req_base), .disp(req_disp), .ea(ea)
    );

    lsq_byte_timer #(.CYC_CLKS(CYC_CLKS)) tmr_i (
        .clk(clk), .rst(rst), .active(active), .cs_n(bus_cs_n),
        .sample_stb(sample_stb), .end_stb(end_stb)
    );

    assign wr_phase  = active && (!is_load || tas_wr);
    assign last_byte = (bidx == 2'(nbytes - 3'd1));
    assign busy      = active;
    assign reg_sel   = active ? cur_reg : req_reg;
    assign bus_addr  = active ? addr_cur : '0;
    assign bus_rw    = !wr_phase;
    assign bus_doe   = wr_phase;
    assign bus_dout  = !wr_phase ? 8'h00 :
                       tas_wr    ? 8'hFF :
                       pick_byte(is_multi ? req_wdata : sdata, nbytes, bidx);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0; is_load <= 1'b0; is_multi <= 1'b0; is_tas <= 1'b0;
            tas_wr <= 1'b0; nbytes <= 3'd1; bidx <= '0; cur_reg <= '0;
            addr_cur <= '0; addr_first <= '0; sdata <= '0; acc <= '0;
            rdata <= '0; reg_we <= '0; done <= 1'b0;
        end else begin
            done   <= 1'b0;
            reg_we <= '0;
            if (accept) begin
                active     <= 1'b1;
                is_load    <= inf.load;
                is_multi   <= inf.multi;
                is_tas     <= inf.tas;
                tas_wr     <= 1'b0;
                nbytes     <= inf.nbytes;
                bidx       <= '0;
                cur_reg    <= req_reg;
                addr_cur   <= ea;
                addr_first <= ea;
                sdata      <= req_wdata;
                acc        <= '0;
            end else if (active) begin
                if (sample_stb && is_load && !tas_wr)
                    acc <= {acc[23:0], bus_din};
                if (end_stb) begin
                    if (last_byte) begin
                        if (is_load && !tas_wr) begin
                            rdata  <= acc;
                            reg_we <= 16'd1 << cur_reg;
                        end
                        if (is_tas && !tas_wr) begin
                            tas_wr   <= 1'b1;
                            nbytes   <= 3'd1;
                            bidx     <= '0;
                            addr_cur <= addr_first;
                        end else if (is_multi && cur_reg != 4'hF) begin
                            cur_reg  <= cur_reg + 1'b1;
                            bidx     <= '0;
                            acc      <= '0;
                            addr_cur <= addr_cur + 1'b1;
                        end else begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end
                    end else begin
                        bidx     <= bidx + 1'b1;
                        addr_cur <= addr_cur + 1'b1;
                    end
                end
            end
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R5
    we_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(reg_we));
    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_cs_n && !$past(bus_cs_n)) |-> $stable(bus_addr));
    // R8
    idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (bus_cs_n && bus_addr == '0 && !bus_doe));
endmodule

// File: tb/bytewise_lsu_tb_top.sv
module bytewise_lsu_tb_top;
    localparam int CYC = 10;
    localparam int LOW = 9;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst, req_valid, req_short, req_base_zero;
    logic [3:0]  req_op, req_reg, reg_sel;
    logic [31:0] req_base, req_wdata, rdata;
    logic [15:0] req_disp, reg_we;
    logic        busy, done, bus_cs_n, bus_rw, bus_doe;
    logic [23:0] bus_addr;
    logic [7:0]  bus_dout, bus_din;

    logic [7:0]  mem  [256];
    logic [7:0]  snap [256];
    logic [31:0] rf   [16];
    logic        tb_multi;
    logic [31:0] wd_direct;

    assign req_wdata = tb_multi ? rf[reg_sel] : wd_direct;
    assign bus_din   = mem[bus_addr[7:0]];
    always @(posedge clk) if (!bus_cs_n && !bus_rw) mem[bus_addr[7:0]] = bus_dout;

    bytewise_lsu #(.CYC_CLKS(CYC)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_short(req_short), .req_base_zero(req_base_zero), .req_base(req_base),
        .req_disp(req_disp), .req_wdata(req_wdata), .req_reg(req_reg),
        .reg_sel(reg_sel), .busy(busy), .done(done), .rdata(rdata), .reg_we(reg_we),
        .bus_cs_n(bus_cs_n), .bus_rw(bus_rw), .bus_addr(bus_addr),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // monitor results of one request
    logic [23:0] alog  [64];
    logic        rwlog [64];
    logic        oelog [64];
    logic [3:0]  wreg  [16];
    logic [31:0] wdat  [16];
    int nlog, nwe, busy_cnt, timing_bad;

    task automatic run_op(input logic [3:0] op, input logic sh, input logic bz,
                          input logic [31:0] base, input logic [15:0] disp,
                          input logic [3:0] rg, input logic multi, input logic poke);
        logic prev_cs;
        int   lowrun;
        req_op = op; req_short = sh; req_base_zero = bz; req_base = base;
        req_disp = disp; req_reg = rg; tb_multi = multi; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        nlog = 0; nwe = 0; busy_cnt = 0; timing_bad = 0; prev_cs = 1'b1; lowrun = 0;
        for (int t = 0; t < 2000; t++) begin
            if (poke && t == 3) begin
                req_op = 4'd4; req_base_zero = 1'b1; req_disp = 16'h0050;
                req_short = 1'b0; req_valid = 1'b1;
            end
            if (poke && t == 4) req_valid = 1'b0;
            if (busy) busy_cnt++;
            if (!bus_cs_n && prev_cs && nlog < 64) begin
                alog[nlog] = bus_addr; rwlog[nlog] = bus_rw; oelog[nlog] = bus_doe;
                nlog++;
            end
            if (!bus_cs_n) lowrun++;
            else if (!prev_cs) begin
                if (lowrun != LOW) timing_bad++;
                lowrun = 0;
            end
            if (reg_we != 16'h0 && nwe < 16) begin
                wreg[nwe] = 4'($clog2(reg_we)); wdat[nwe] = rdata; nwe++;
            end
            if (done) break;
            prev_cs = bus_cs_n;
            @(negedge clk);
        end
    endtask

    task automatic preset_mem;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        for (int i = 0; i < 256; i++) snap[i] = mem[i];
    endtask

    typedef struct packed {
        logic [3:0]  op;
        logic        sh;
        logic        bz;
        logic [23:0] base;
        logic [15:0] disp;
        logic [31:0] wd;
        logic [23:0] ea;
        logic [2:0]  nb;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{4'd0, 1'b0, 1'b0, 24'h000010, 16'h0005, 32'h0,        24'h000015, 3'd1},
        '{4'd1, 1'b0, 1'b1, 24'h123456, 16'h0020, 32'h0,        24'h000020, 3'd2},
        '{4'd2, 1'b0, 1'b0, 24'h000040, 16'hFFFC, 32'h0,        24'h00003C, 3'd4},
        '{4'd1, 1'b1, 1'b0, 24'h000080, 16'h0003, 32'h0,        24'h000086, 3'd2},
        '{4'd2, 1'b1, 1'b0, 24'h000080, 16'hFF0F, 32'h0,        24'h0000BC, 3'd4},
        '{4'd6, 1'b0, 1'b0, 24'h0000A0, 16'h0000, 32'hDEADBEEF, 24'h0000A0, 3'd4},
        '{4'd5, 1'b1, 1'b0, 24'h000090, 16'h0002, 32'h1234ABCD, 24'h000094, 3'd2},
        '{4'd4, 1'b0, 1'b1, 24'h000000, 16'h00C8, 32'h00000077, 24'h0000C8, 3'd1},
        '{4'd0, 1'b1, 1'b0, 24'hFFFFFF, 16'h0001, 32'h0,        24'h000000, 3'd1},
        '{4'd2, 1'b0, 1'b0, 24'hFFFFFE, 16'h0000, 32'h0,        24'hFFFFFE, 3'd4}
    };

    initial begin
        logic [31:0] expw;
        rst = 1'b1; req_valid = 1'b0; req_op = '0; req_short = 1'b0;
        req_base_zero = 1'b0; req_base = '0; req_disp = '0; req_reg = '0;
        tb_multi = 1'b0; wd_direct = '0;
        for (int i = 0; i < 16; i++) rf[i] = 32'h0;
        preset_mem();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 / R8 reset state
        chk("R10", "busy", {31'b0, busy}, 32'd0);
        chk("R10", "done", {31'b0, done}, 32'd0);
        chk("R10", "reg_we", {16'b0, reg_we}, 32'd0);
        chk("R8", "idle cs_n/rw/doe", {29'b0, bus_cs_n, bus_rw, bus_doe}, 32'd6);
        chk("R8", "idle addr", {8'b0, bus_addr}, 32'd0);

        // table of single accesses
        for (int v = 0; v < 10; v++) begin
            preset_mem();
            wd_direct = VECS[v].wd;
            run_op(VECS[v].op, VECS[v].sh, VECS[v].bz, {8'hA5, VECS[v].base},
                   VECS[v].disp, 4'd5, 1'b0, 1'b0);
            chk("R1 R2", "first address", {8'b0, alog[0]}, {8'b0, VECS[v].ea});
            chk("R9", "byte count", nlog, 32'(VECS[v].nb));
            chk("R9", "busy length", busy_cnt, 32'(VECS[v].nb) * CYC);
            chk("R7", "select low length", timing_bad, 32'd0);
            chk("R8", "idle after done", {bus_cs_n, bus_rw, bus_doe, bus_addr}, {3'b110, 24'h0});
            for (int k = 1; k < 4; k++)
                if (k < int'(VECS[v].nb))
                    chk("R1", "consecutive address", {8'b0, alog[k]},
                        {8'b0, VECS[v].ea + 24'(k)});
            if (VECS[v].op < 4'd4) begin
                expw = '0;
                for (int k = 0; k < 4; k++)
                    if (k < int'(VECS[v].nb))
                        expw = {expw[23:0], snap[8'(VECS[v].ea) + 8'(k)]};
                chk("R3", "strobe count", nwe, 32'd1);
                chk("R3", "strobe register", {28'b0, wreg[0]}, 32'd5);
                chk("R3", "load data", wdat[0], expw);
            end else begin
                chk("R8", "store drive", {30'b0, oelog[0], rwlog[0]}, 32'd2);
                chk("R4", "no strobe on store", nwe, 32'd0);
                for (int k = 0; k < 4; k++)
                    if (k < int'(VECS[v].nb))
                        chk("R4", "stored byte",
                            {24'b0, mem[8'(VECS[v].ea) + 8'(k)]},
                            {24'b0, VECS[v].wd[8*(int'(VECS[v].nb)-1-k) +: 8]});
            end
            @(negedge clk);
        end

        // R5 multiple load from 13, short flag must be ignored
        preset_mem();
        run_op(4'd3, 1'b1, 1'b0, 32'h00000010, 16'h0004, 4'd13, 1'b0, 1'b0);
        chk("R5", "multi load bytes", nlog, 32'd12);
        chk("R2", "short ignored on multi", {8'b0, alog[0]}, 32'h14);
        chk("R5", "multi load strobes", nwe, 32'd3);
        for (int r = 0; r < 3; r++) begin
            expw = {snap[8'h14 + 8'(4*r)], snap[8'h15 + 8'(4*r)],
                    snap[8'h16 + 8'(4*r)], snap[8'h17 + 8'(4*r)]};
            chk("R5", "multi register order", {28'b0, wreg[r]}, 32'(13 + r));
            chk("R5", "multi word", wdat[r], expw);
        end
        chk("R5", "last address", {8'b0, alog[11]}, 32'h1F);
        @(negedge clk);

        // R5 multiple store from 14
        preset_mem();
        rf[14] = 32'hCAFEF00D; rf[15] = 32'h01234567;
        run_op(4'd7, 1'b0, 1'b1, 32'h0, 16'h0060, 4'd14, 1'b1, 1'b0);
        tb_multi = 1'b0;
        chk("R5", "multi store bytes", nlog, 32'd8);
        chk("R5", "multi store lo word",
            {mem[8'h60], mem[8'h61], mem[8'h62], mem[8'h63]}, 32'hCAFEF00D);
        chk("R5", "multi store hi word",
            {mem[8'h64], mem[8'h65], mem[8'h66], mem[8'h67]}, 32'h01234567);
        @(negedge clk);

        // R6 test-and-set
        preset_mem();
        mem[8'h30] = 8'h12; mem[8'h31] = 8'h34;
        run_op(4'd8, 1'b1, 1'b1, 32'h0, 16'h0030, 4'd2, 1'b0, 1'b0);
        chk("R6", "tas bytes", nlog, 32'd3);
        chk("R6", "tas write address", {8'b0, alog[2]}, 32'h30);
        chk("R6", "tas write direction", {31'b0, rwlog[2]}, 32'd0);
        chk("R6", "tas read value", wdat[0], 32'h00001234);
        chk("R6", "tas strobe register", {28'b0, wreg[0]}, 32'd2);
        chk("R6", "tas marked byte", {24'b0, mem[8'h30]}, 32'hFF);
        chk("R6", "tas second byte kept", {24'b0, mem[8'h31]}, 32'h34);
        @(negedge clk);

        // R9 request during busy is ignored
        preset_mem();
        mem[8'h50] = 8'h00; wd_direct = 32'h99;
        run_op(4'd0, 1'b0, 1'b1, 32'h0, 16'h0011, 4'd1, 1'b0, 1'b1);
        chk("R9", "busy request: byte count", nlog, 32'd1);
        begin
            int extra = 0;
            for (int t = 0; t < 30; t++) begin
                @(negedge clk);
                if (busy || !bus_cs_n) extra++;
            end
            chk("R9", "no later activity", extra, 32'd0);
        end
        chk("R9", "ignored store left memory", {24'b0, mem[8'h50]}, 32'h0);

        // R11 undefined code ignored
        req_op = 4'hC; req_valid = 1'b1; req_base_zero = 1'b1; req_disp = 16'h0050;
        @(negedge clk);
        req_valid = 1'b0;
        begin
            int act = 0;
            for (int t = 0; t < 20; t++) begin
                if (busy || !bus_cs_n || done) act++;
                @(negedge clk);
            end
            chk("R11", "undefined code activity", act, 32'd0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule